// File: doc/BRIEF.md
# Mailbox Command Decoder for Simulation Control

The block owns a pair of 64-bit mailbox registers, one written by the target (outbound) and one by the host side (inbound). Both sit at all ones after reset. Every accepted write to the outbound mailbox is decoded at once. The word is split into an 8-bit device code, an 8-bit command code and a 48-bit payload. The result is either an immediate stop request that carries an exit code, or a fetch of an eight-doubleword system-call descriptor from memory.

When the descriptor has been read, its first word picks the outcome. A value of 64 becomes a console write command, with file descriptor, buffer pointer and byte length taken from descriptor words one to three. Any other value becomes a stop request. Only one command is in flight at a time: while the descriptor fetch runs, `busy_o` is high and further outbound writes are dropped. With the `XLEN` parameter set to 32, device and command are taken as zero and the payload is the zero-extended register value.

Top module: `hostif_tohost_decoder`

## Requirements
- R1: After reset both mailbox outputs read all ones, and `busy_o`, `mem_req_o`, `halt_o` and `wr_cmd_valid_o` are low.
- R2: The device code is bits [63:56] of the written word, the command code is bits [55:48], and the payload is bits [47:0].
- R3: A write whose payload bit 0 is 1 pulses `halt_o` for one cycle, starting the cycle after the write edge, with `exit_code_o` equal to the payload. This holds whatever the device and command codes are. `tohost_o` shows the written word for that cycle and reads all ones from the next one.
- R4: A write with bit 0 clear and a nonzero device or command code produces the same one-cycle stop request carrying the payload, and no memory read.
- R5: A write with device and command zero and bit 0 clear raises `busy_o` from the next cycle. The block then reads exactly eight doublewords, at payload + 8*k for k = 0..7 in ascending order, with one request outstanding at a time.
- R6: If descriptor word 0 equals 64, `wr_cmd_valid_o` pulses for one cycle in the cycle after the last read data is taken. `wr_fd_o`, `wr_buf_o` and `wr_len_o` carry descriptor words 1, 2 and 3. `busy_o` falls in that same cycle and `tohost_o` returns to all ones.
- R7: If descriptor word 0 is any value other than 64, a one-cycle stop request is issued at the same point instead, with `exit_code_o` equal to the payload of the command word.
- R8: A write to the outbound mailbox while `busy_o` is high is ignored: `tohost_o` keeps the command word, and no extra stop or write result appears.
- R9: A write to the inbound mailbox updates `fromhost_o` on the next cycle and triggers no decode, fetch or result.
- R10: While `mem_req_o` is high and no read data has been returned, `mem_addr_o` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tohost_we_i | input | 1 | Write strobe for the outbound mailbox |
| fromhost_we_i | input | 1 | Write strobe for the inbound mailbox |
| wdata_i | input | XLEN | Write data for either mailbox |
| tohost_o | output | XLEN | Outbound mailbox contents |
| fromhost_o | output | XLEN | Inbound mailbox contents |
| busy_o | output | 1 | Descriptor fetch in progress; outbound writes dropped |
| mem_req_o | output | 1 | Read request, held until data returns |
| mem_addr_o | output | 48 | Byte address of the requested doubleword |
| mem_rvalid_i | input | 1 | Read data valid; completes the current request |
| mem_rdata_i | input | 64 | Read data |
| halt_o | output | 1 | One-cycle stop request |
| exit_code_o | output | 48 | Exit code that goes with `halt_o` |
| wr_cmd_valid_o | output | 1 | One-cycle console write command |
| wr_fd_o | output | 64 | File descriptor of the write command |
| wr_buf_o | output | 64 | Buffer pointer of the write command |
| wr_len_o | output | 64 | Byte length of the write command |

## Verification
The assertions assume that memory raises `mem_rvalid_i` only while `mem_req_o` is high, for one cycle per word, and that no outbound write arrives in the same cycle as a previous result except through the normal idle path. The bench memory model answers only an open request and drops valid after one cycle. It can insert a fixed number of wait cycles before each answer, which keeps the request open long enough to exercise the address hold. All writes are driven on the falling edge, so decode inputs never change near the sampling edge.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned PAY_W  = 48;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_HALT    = 2'd1,
    REQ_SYSCALL = 2'd2
  } req_kind_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/hostif_field_decode.sv
module hostif_field_decode
  import hostif_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned DEV_LSB = 56,
  parameter int unsigned CMD_LSB = 48
) (
  input  logic [XLEN-1:0]  word_i,
  output logic [7:0]       device_o,
  output logic [7:0]       command_o,
  output logic [PAY_W-1:0] payload_o,
  output req_kind_e        kind_o
);
  generate
    if (XLEN >= 64) begin : g_wide
      assign device_o  = word_i[DEV_LSB +: 8];
      assign command_o = word_i[CMD_LSB +: 8];
      assign payload_o = word_i[PAY_W-1:0];
    end else begin : g_narrow
      // narrow registers carry no routing fields
      assign device_o  = 8'h00;
      assign command_o = 8'h00;
      assign payload_o = PAY_W'(word_i);
    end
  endgenerate

  always_comb begin
    if (payload_o[0])
      kind_o = REQ_HALT;
    else if ((device_o != 8'h00) || (command_o != 8'h00))
      kind_o = REQ_HALT;
    else
      kind_o = REQ_SYSCALL;
  end
endmodule

// File: rtl/hostif_desc_fetch.sv
module hostif_desc_fetch
  import hostif_pkg::*;
#(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned DESC_WORDS = 8,
  parameter int unsigned KEEP_WORDS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          base_i,
  output logic                       req_o,
  output logic [ADDR_W-1:0]          addr_o,
  input  logic                       rvalid_i,
  input  word_t                      rdata_i,
  output logic                       done_o,
  output logic [KEEP_WORDS-1:0][WORD_W-1:0] words_o
);
  localparam int unsigned IDX_W = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);
  localparam int unsigned STRIDE_SH = 3;

  logic              active_q;
  logic              done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              take;

  assign take   = active_q && rvalid_i;
  assign req_o  = active_q;
  assign done_o = done_q;
  assign addr_o = base_q + (ADDR_W'(idx_q) << STRIDE_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        base_q   <= base_i;
      end else if (take) begin
        if (idx_q == LAST_IDX) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < KEEP_WORDS; g++) begin : g_keep
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          words_o[g] <= '0;
        else if (take && (idx_q == IDX_W'(g)))
          words_o[g] <= rdata_i;
      end
    end
  endgenerate

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rvalid_i) |=> $stable(addr_o)); // R10

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (idx_q != LAST_IDX)) |=> (addr_o == $past(addr_o) + ADDR_W'(8))); // R5

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (idx_q <= LAST_IDX)); // R5

  AST_DONE_ENDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o); // R5
endmodule

// File: rtl/hostif_syscall_classify.sv
module hostif_syscall_classify
  import hostif_pkg::*;
#(
  parameter int unsigned KEEP_WORDS   = 4,
  parameter logic [63:0] SYS_WRITE_ID = 64'd64
) (
  input  logic [KEEP_WORDS-1:0][WORD_W-1:0] words_i,
  output logic  is_write_o,
  output word_t fd_o,
  output word_t buf_o,
  output word_t len_o
);
  assign is_write_o = (words_i[0] == SYS_WRITE_ID);
  assign fd_o       = words_i[1];
  assign buf_o      = words_i[2];
  assign len_o      = words_i[3];
endmodule

// File: rtl/hostif_tohost_decoder.sv
module hostif_tohost_decoder
  import hostif_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned DESC_WORDS = 8,
  parameter logic [63:0] SYS_WRITE_ID = 64'd64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tohost_we_i,
  input  logic             fromhost_we_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [XLEN-1:0]  tohost_o,
  output logic [XLEN-1:0]  fromhost_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [47:0]      mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             halt_o,
  output logic [47:0]      exit_code_o,
  output logic             wr_cmd_valid_o,
  output logic [63:0]      wr_fd_o,
  output logic [63:0]      wr_buf_o,
  output logic [63:0]      wr_len_o
);
  localparam int unsigned KEEP_WORDS = 4;
  localparam logic [XLEN-1:0] IDLE_VAL = '1;

  ctl_state_e        state_q;
  logic [XLEN-1:0]   tohost_q, fromhost_q;
  logic [PAY_W-1:0]  payload_q, exit_q;
  logic              halt_q, cmd_q;
  word_t             fd_q, buf_q, len_q;

  logic [7:0]        dec_dev, dec_cmd;
  logic [PAY_W-1:0]  dec_pay;
  req_kind_e         dec_kind;
  logic              accept, fetch_start, fetch_done;
  logic [KEEP_WORDS-1:0][WORD_W-1:0] desc_words;
  logic              cls_write;
  word_t             cls_fd, cls_buf, cls_len;

  hostif_field_decode #(.XLEN(XLEN)) u_decode (
    .word_i    (wdata_i),
    .device_o  (dec_dev),
    .command_o (dec_cmd),
    .payload_o (dec_pay),
    .kind_o    (dec_kind)
  );

  assign accept      = tohost_we_i && (state_q == ST_IDLE);
  assign fetch_start = accept && (dec_kind == REQ_SYSCALL);

  hostif_desc_fetch #(
    .ADDR_W(PAY_W), .DESC_WORDS(DESC_WORDS), .KEEP_WORDS(KEEP_WORDS)
  ) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (fetch_start),
    .base_i   (dec_pay),
    .req_o    (mem_req_o),
    .addr_o   (mem_addr_o),
    .rvalid_i (mem_rvalid_i),
    .rdata_i  (mem_rdata_i),
    .done_o   (fetch_done),
    .words_o  (desc_words)
  );

  hostif_syscall_classify #(
    .KEEP_WORDS(KEEP_WORDS), .SYS_WRITE_ID(SYS_WRITE_ID)
  ) u_classify (
    .words_i    (desc_words),
    .is_write_o (cls_write),
    .fd_o       (cls_fd),
    .buf_o      (cls_buf),
    .len_o      (cls_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      fromhost_q <= IDLE_VAL;
    else if (fromhost_we_i)
      fromhost_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tohost_q  <= IDLE_VAL;
      payload_q <= '0;
      exit_q    <= '0;
      halt_q    <= 1'b0;
      cmd_q     <= 1'b0;
      fd_q      <= '0;
      buf_q     <= '0;
      len_q     <= '0;
    end else begin
      halt_q <= 1'b0;
      cmd_q  <= 1'b0;
      if (accept) begin
        tohost_q  <= wdata_i;
        payload_q <= dec_pay;
        if (dec_kind == REQ_HALT) begin
          halt_q <= 1'b1;
          exit_q <= dec_pay;
        end else if (dec_kind == REQ_SYSCALL) begin
          state_q <= ST_FETCH;
        end
      end else if (halt_q) begin
        // mailbox reads idle once the stop has been issued
        tohost_q <= IDLE_VAL;
      end
      if ((state_q == ST_FETCH) && fetch_done) begin
        state_q  <= ST_IDLE;
        tohost_q <= IDLE_VAL;
        if (cls_write) begin
          cmd_q <= 1'b1;
          fd_q  <= cls_fd;
          buf_q <= cls_buf;
          len_q <= cls_len;
        end else begin
          halt_q <= 1'b1;
          exit_q <= payload_q;
        end
      end
    end
  end

  assign tohost_o       = tohost_q;
  assign fromhost_o     = fromhost_q;
  assign busy_o         = (state_q == ST_FETCH);
  assign halt_o         = halt_q;
  assign exit_code_o    = exit_q;
  assign wr_cmd_valid_o = cmd_q;
  assign wr_fd_o        = fd_q;
  assign wr_buf_o       = buf_q;
  assign wr_len_o       = len_q;

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_o && wr_cmd_valid_o)); // R6

  AST_REQ_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R5

  AST_TOHOST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fetch_done) |=> $stable(tohost_o)); // R8

  AST_CMD_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_valid_o |-> ($past(busy_o) && !busy_o)); // R6

  AST_FETCH_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_done |-> busy_o); // R7
endmodule

// File: tb/hostif_tohost_decoder_test.sv
`timescale 1ns/1ps
module hostif_tohost_decoder_test;
  localparam time TCK = 8ns;
  localparam logic [63:0] ONES = '1;

  typedef struct packed {
    logic        is_cmd;
    int          req;
    logic [47:0] code;
    logic [63:0] fd;
    logic [63:0] bp;
    logic [63:0] len;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tohost_we = 1'b0, fromhost_we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] tohost, fromhost;
  logic        busy, mem_req, mem_rvalid = 1'b0;
  logic [47:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        halt, wr_cmd;
  logic [47:0] exit_code;
  logic [63:0] wr_fd, wr_buf, wr_len;

  int   n_cmp = 0, n_bad = 0;
  exp_t sb_q[$];
  logic [63:0] desc_mem [8];
  logic [47:0] cur_base = '0;
  int   fetched = 0, stall_n = 0, wait_cnt = 0;
  bit   done_flag = 1'b0;

  always #(TCK/2) clk = ~clk;

  hostif_tohost_decoder uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tohost_we_i(tohost_we), .fromhost_we_i(fromhost_we), .wdata_i(wdata),
    .tohost_o(tohost), .fromhost_o(fromhost), .busy_o(busy),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .halt_o(halt), .exit_code_o(exit_code),
    .wr_cmd_valid_o(wr_cmd), .wr_fd_o(wr_fd), .wr_buf_o(wr_buf), .wr_len_o(wr_len)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_halt(input int req, input logic [47:0] code);
    exp_t e;
    e = '0; e.req = req; e.code = code;
    sb_q.push_back(e);
  endtask

  task automatic push_cmd(input int req, input logic [63:0] fd, input logic [63:0] bp, input logic [63:0] len);
    exp_t e;
    e = '0; e.is_cmd = 1'b1; e.req = req; e.fd = fd; e.bp = bp; e.len = len;
    sb_q.push_back(e);
  endtask

  task automatic wr_tohost(input logic [63:0] v);
    @(negedge clk); tohost_we = 1'b1; wdata = v;
    @(negedge clk); tohost_we = 1'b0;
  endtask

  task automatic set_desc(input logic [47:0] base, input logic [63:0] num,
                          input logic [63:0] fd, input logic [63:0] bp, input logic [63:0] len);
    cur_base = base; fetched = 0;
    desc_mem[0] = num; desc_mem[1] = fd; desc_mem[2] = bp; desc_mem[3] = len;
    for (int k = 4; k < 8; k++) desc_mem[k] = 64'hA5A5_0000_0000_0000 | 64'(k);
  endtask

  task automatic wait_idle(input string req);
    int n;
    n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, req, 64'(sb_q.size()), 64'd0);
  endtask

  // memory model: answers an open request, optional wait cycles per word
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
      end else if (mem_req) begin
        if (wait_cnt < stall_n) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          // R5 ascending doubleword addresses
          chk(mem_addr == cur_base + 48'(fetched * 8), "R5 addr", 64'(mem_addr),
              64'(cur_base + 48'(fetched * 8)));
          mem_rdata  = (fetched < 8) ? desc_mem[fetched] : '0;
          mem_rvalid = 1'b1;
          fetched++;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && (halt || wr_cmd)) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", {62'd0, wr_cmd, halt}, 64'd0);
        end else begin
          e = sb_q.pop_front();
          if (e.is_cmd) begin
            chk(wr_cmd && !halt, $sformatf("R%0d kind", e.req), {63'd0, wr_cmd}, 64'd1);
            chk(wr_fd == e.fd, "R6 fd", wr_fd, e.fd);
            chk(wr_buf == e.bp, "R6 buf", wr_buf, e.bp);
            chk(wr_len == e.len, "R6 len", wr_len, e.len);
            chk(!busy, "R6 busy drop", {63'd0, busy}, 64'd0);
            chk(tohost == ONES, "R6 tohost idle", tohost, ONES);
          end else begin
            chk(halt && !wr_cmd, $sformatf("R%0d kind", e.req), {63'd0, halt}, 64'd1);
            chk(exit_code == e.code, $sformatf("R%0d exit", e.req), 64'(exit_code), 64'(e.code));
          end
        end
      end
    end
  end

  initial begin
    #(TCK * 20000);
    if (!done_flag) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tohost == ONES, "R1 tohost", tohost, ONES);
    chk(fromhost == ONES, "R1 fromhost", fromhost, ONES);
    chk({busy, mem_req, halt, wr_cmd} == 4'b0, "R1 idle outputs", 64'({busy, mem_req, halt, wr_cmd}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 odd payload, zero routing fields
    push_halt(3, 48'h55);
    wr_tohost(64'h0000_0000_0000_0055);
    chk(tohost == 64'h55, "R3 tohost shows word", tohost, 64'h55);
    @(negedge clk);
    chk(tohost == ONES, "R3 tohost idle", tohost, ONES);
    wait_idle("R3 drained");

    // R3 odd payload wins over nonzero routing fields (R2 layout)
    fetched = 0;
    push_halt(3, 48'h0000_0000_0003);
    wr_tohost(64'h0102_0000_0000_0003);
    wait_idle("R3 drained");
    chk(fetched == 0, "R3 no fetch", 64'(fetched), 64'd0);

    // R4 nonzero device, even payload
    push_halt(4, 48'h0000_0000_1000);
    wr_tohost(64'h0100_0000_0000_1000);
    wait_idle("R4 drained");
    chk(fetched == 0, "R4 no fetch", 64'(fetched), 64'd0);

    // R2 nonzero command only, payload from bits 47:0
    push_halt(2, 48'h1234_5678_0000);
    wr_tohost(64'h0001_1234_5678_0000);
    wait_idle("R2 drained");
    chk(fetched == 0, "R4 no fetch on command", 64'(fetched), 64'd0);

    // R5 R6 console write, no wait cycles
    stall_n = 0;
    set_desc(48'h0000_0000_8000, 64'd64, 64'd1, 64'hDEAD_BEE0, 64'd13);
    push_cmd(6, 64'd1, 64'hDEAD_BEE0, 64'd13);
    wr_tohost(64'h0000_0000_0000_8000);
    chk(busy, "R5 busy", {63'd0, busy}, 64'd1);
    chk(tohost == 64'h8000, "R5 tohost held", tohost, 64'h8000);
    wait_idle("R6 drained");
    chk(fetched == 8, "R5 eight words", 64'(fetched), 64'd8);

    // R10 R6 console write with wait cycles on every word
    stall_n = 2;
    set_desc(48'h7FFF_FFFF_FF00, 64'd64, 64'd2, 64'h0000_0001_0000_0040, 64'hFFFF);
    push_cmd(10, 64'd2, 64'h0000_0001_0000_0040, 64'hFFFF);
    wr_tohost(64'h0000_7FFF_FFFF_FF00);
    wait_idle("R10 drained");
    chk(fetched == 8, "R10 eight words", 64'(fetched), 64'd8);

    // R7 unknown call number
    stall_n = 1;
    set_desc(48'h0000_0000_2000, 64'd93, 64'd0, 64'd0, 64'd0);
    push_halt(7, 48'h2000);
    wr_tohost(64'h0000_0000_0000_2000);
    wait_idle("R7 drained");
    chk(fetched == 8, "R7 eight words", 64'(fetched), 64'd8);
    chk(tohost == ONES, "R7 tohost idle", tohost, ONES);

    // R8 writes while busy are dropped
    stall_n = 3;
    set_desc(48'h0000_0000_4000, 64'd64, 64'd3, 64'h4444, 64'd7);
    push_cmd(8, 64'd3, 64'h4444, 64'd7);
    wr_tohost(64'h0000_0000_0000_4000);
    wr_tohost(64'h0000_0000_0000_0077);
    chk(tohost == 64'h4000, "R8 tohost kept", tohost, 64'h4000);
    chk(busy, "R8 still busy", {63'd0, busy}, 64'd1);
    wr_tohost(64'h0100_0000_0000_0000);
    chk(tohost == 64'h4000, "R8 tohost kept", tohost, 64'h4000);
    wait_idle("R8 drained");

    // R9 inbound mailbox write
    stall_n = 0;
    fetched = 0;
    @(negedge clk); fromhost_we = 1'b1; wdata = 64'h0000_0000_0000_1234;
    @(negedge clk); fromhost_we = 1'b0;
    chk(fromhost == 64'h1234, "R9 fromhost", fromhost, 64'h1234);
    chk(tohost == ONES, "R9 tohost untouched", tohost, ONES);
    chk(!busy, "R9 no busy", {63'd0, busy}, 64'd0);
    wait_idle("R9 no result");
    chk(fetched == 0, "R9 no fetch", 64'(fetched), 64'd0);

    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule